// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external 16-bit asynchronous static RAM. The host hands it one command at a time: a read or a write, an 18-bit word address, write data and a two-bit byte mask. The controller turns each command into a sequence of registered, active-low chip-select, output-enable, write-enable and byte-lane strobe levels. It drives the data bus only while a write needs it. Every timing phase is held for a whole number of clock cycles. These counts come from the RAM's timing figures in picoseconds, divided by the clock period and rounded up, with a floor of one cycle.

The command port is valid/ready. A command transfers on a rising edge where both `req_valid` and `req_ready` are high. A host that sees `req_ready` low keeps the command stable and keeps `req_valid` asserted. `req_ready` does not depend on `req_valid`. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse and `rsp_rdata` holds its value until the next read completes.

A write accepted in the last cycle of the previous write is chained onto it. Write enable and chip select stay low, and the new word is framed by the byte strobes alone. The data bus is separated into an output value, an output enable and an input value, so that the pad ring can build the tri-state buffer.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, chip select, output enable, write enable and both byte strobes are high, the data bus enable is low, `rsp_valid` is low and `req_ready` is high.
- R2: `req_ready` is high only while idle or in the final cycle of a write. In every other cycle, including the cycle after any accepted command, it is low.
- R3: During a write, output enable stays high. The byte strobes of the selected lanes stay low for exactly WP_CYC cycles, with chip select and write enable low throughout.
- R4: The data bus enable is high only while write enable and chip select are low. It is never high in the cycle in which write enable falls. It stays high for one cycle after the strobes rise, so that the written data is held.
- R5: `req_mask` bit 0 selects bits 7:0 through the lower strobe (`mem_lb_n`), and bit 1 selects bits 15:8 through the upper strobe (`mem_ub_n`). A lane whose mask bit is 0 keeps its strobe high, and a write with mask 00 changes no memory contents.
- R6: A read holds chip select, output enable and the selected lane strobes low, with write enable high, for RD_CYC cycles. The bus is sampled on the edge that ends the last of these cycles. The bits of lanes that were not selected return as zero.
- R7: `rsp_valid` is high for exactly one cycle, RD_CYC cycles after the cycle in which a read is accepted from idle. `rsp_rdata` carries the sampled word.
- R8: A write accepted in the final cycle of a write keeps write enable and chip select low between the two words. Write enable then rises only once for the whole chain.
- R9: After a write, the bus enable is low and chip select, output enable and write enable are high for TURN_CYC cycles before a following read lowers output enable. The bus enable and a low output enable never coincide.
- R10: After a write enable fall that starts a write, AS_CYC cycles pass before the strobes fall. All cycle counts equal the ceiling of the matching picosecond parameter over CLK_PS, and are at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Controller can take a command this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | 16 | Read word, unselected lanes zero |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_dq_out | output | 16 | Value to drive on the RAM data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Value read from the RAM data bus |

## Verification
The RAM model in the bench returns filler data until a read has been held for the full access count, and fills unselected lanes with filler bytes. A controller that samples a cycle early, or that fails to clear unselected lanes, therefore returns a wrong word. Chained writes are issued without gaps, and the bench counts write-enable rising edges. A design that lets write enable rise between the words shows more than one edge. A design that drops the held data loses the second word.

A read is also issued into the last cycle of a write, to measure the idle gap between the write data drive and the read's output enable. A missing turnaround shows up as contention or a zero gap. Lane-only writes and a mask-00 write are read back, so that a strobe decoded on the wrong lane corrupts the merged word. Strobe width, address setup and any bus drive in the cycle where write enable falls are measured on every write.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WSTB,
    ST_WEND,
    ST_REL,
    ST_RACC
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
    logic lane_en;
  } ctl_t;

  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic ctl_t decode_ctl(input seq_state_e st);
    ctl_t c;
    c = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, lane_en: 1'b0};
    case (st)
      ST_WSET: begin c.ce_n = 1'b0; c.we_n = 1'b0; end
      ST_WSTB: begin c.ce_n = 1'b0; c.we_n = 1'b0; c.dq_oe = 1'b1; c.lane_en = 1'b1; end
      ST_WEND: begin c.ce_n = 1'b0; c.we_n = 1'b0; c.dq_oe = 1'b1; end
      ST_RACC: begin c.ce_n = 1'b0; c.oe_n = 1'b0; c.lane_en = 1'b1; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val - 1'b1;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_lane_ctrl.sv
`timescale 1ns/1ps
module asram_lane_ctrl #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_d,
  input  logic [LANES-1:0]   mask_d,
  input  logic               capture,
  input  logic [LANES-1:0]   cap_mask,
  input  logic [8*LANES-1:0] dq_in,
  output logic [LANES-1:0]   stb_n,
  output logic [8*LANES-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) stb_n[g] <= 1'b1;
      else     stb_n[g] <= ~(en_d & mask_d[g]);
    end

    always_ff @(posedge clk) begin
      if (rst)
        rdata[8*g +: 8] <= '0;
      else if (capture)
        rdata[8*g +: 8] <= cap_mask[g] ? dq_in[8*g +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int LANES    = 2,
  parameter int CW       = 4,
  parameter int AS_CYC   = 1,
  parameter int WP_CYC   = 1,
  parameter int RD_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dq_oe,
  output logic              lane_en_d,
  output logic [LANES-1:0]  mask_d,
  output logic [LANES-1:0]  mask_q,
  output logic              capture,
  output logic              rsp_valid
);
  seq_state_e        state_q, state_d;
  logic              pend_q, pend_d;
  logic              accept;
  logic              tmr_load, tmr_done;
  logic [CW-1:0]     tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  ctl_t              ctl_d;

  assign req_ready = (state_q == ST_IDLE) || (state_q == ST_WEND);
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_RACC) && tmr_done;
  assign mask_d    = accept ? req_mask : mask_q;

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    tmr_load = 1'b0;
    tmr_val  = CW'(1);
    case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (req_write) begin state_d = ST_WSET; tmr_val = CW'(AS_CYC); end
        else           begin state_d = ST_RACC; tmr_val = CW'(RD_CYC); end
      end
      ST_WSET: if (tmr_done) begin
        state_d = ST_WSTB; tmr_load = 1'b1; tmr_val = CW'(WP_CYC);
      end
      ST_WSTB: if (tmr_done) state_d = ST_WEND;
      ST_WEND: begin
        tmr_load = 1'b1;
        if (accept && req_write) begin
          state_d = ST_WSET; tmr_val = CW'(AS_CYC);
        end else begin
          state_d = ST_REL; tmr_val = CW'(TURN_CYC);
          pend_d  = accept;
        end
      end
      ST_REL: if (tmr_done) begin
        if (pend_q) begin
          state_d = ST_RACC; pend_d = 1'b0; tmr_load = 1'b1; tmr_val = CW'(RD_CYC);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_RACC: if (tmr_done) begin
        state_d = ST_REL; tmr_load = 1'b1; tmr_val = CW'(TURN_CYC);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctl_d     = decode_ctl(state_d);
  assign lane_en_d = ctl_d.lane_en;

  asram_phase_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      mask_q    <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      mask_q    <= mask_d;
      mem_ce_n  <= ctl_d.ce_n;
      mem_oe_n  <= ctl_d.oe_n;
      mem_we_n  <= ctl_d.we_n;
      mem_dq_oe <= ctl_d.dq_oe;
      rsp_valid <= capture;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int CLK_PS     = 10000,
  parameter int T_WEHZ_PS  = 5000,
  parameter int T_WP_PS    = 8000,
  parameter int T_SD_PS    = 6000,
  parameter int T_WC_PS    = 10000,
  parameter int T_RD_PS    = 10000,
  parameter int T_HZ_PS    = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);
  localparam int LANES    = 2;
  localparam int DATA_W   = 8 * LANES;
  localparam int AS_CYC   = ps_to_cyc(T_WEHZ_PS, CLK_PS);
  localparam int WC_REST  = ps_to_cyc(T_WC_PS, CLK_PS) - AS_CYC - 1;
  localparam int WP_CYC   = umax(umax(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_SD_PS, CLK_PS)),
                                 (WC_REST < 1) ? 1 : WC_REST);
  localparam int RD_CYC   = ps_to_cyc(T_RD_PS, CLK_PS);
  localparam int TURN_CYC = ps_to_cyc(T_HZ_PS, CLK_PS);
  localparam int MAX_CYC  = umax(umax(AS_CYC, WP_CYC), umax(RD_CYC, TURN_CYC));
  localparam int CW       = $clog2(MAX_CYC + 1);

  logic              lane_en_d, capture;
  logic [LANES-1:0]  mask_d, mask_q, stb_n;

  asram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .CW(CW),
    .AS_CYC(AS_CYC), .WP_CYC(WP_CYC), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_dq_out),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .lane_en_d (lane_en_d),
    .mask_d    (mask_d),
    .mask_q    (mask_q),
    .capture   (capture),
    .rsp_valid (rsp_valid)
  );

  asram_lane_ctrl #(.LANES(LANES)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .en_d     (lane_en_d),
    .mask_d   (mask_d),
    .capture  (capture),
    .cap_mask (mask_q),
    .dq_in    (mem_dq_in),
    .stb_n    (stb_n),
    .rdata    (rsp_rdata)
  );

  assign mem_lb_n = stb_n[0];
  assign mem_ub_n = stb_n[1];
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int WP_CYC = 1
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_ub_n,
  input logic mem_lb_n,
  input logic mem_dq_oe
);
  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)                                      run_q <= '0;
    else if (!mem_we_n && !(mem_ub_n && mem_lb_n)) run_q <= run_q + 1'b1;
    else                                          run_q <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe && !rsp_valid)); // R1
  AST_READY_LOW_IN_READ: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !req_ready); // R2
  AST_OE_HIGH_WRITING: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n); // R3
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && mem_ub_n && mem_lb_n && run_q != 8'd0) |-> (run_q == 8'(WP_CYC))); // R3
  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n)); // R4
  AST_NO_DRIVE_AT_WE_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> !mem_dq_oe); // R4
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !(mem_ub_n && mem_lb_n) |-> !mem_ce_n); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R7
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R9
endmodule

bind asram_ctrl asram_ctrl_chk #(.WP_CYC(WP_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_ub_n  (mem_ub_n),
  .mem_lb_n  (mem_lb_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;
  // Slow RAM grade at 20 ns clock: AS=1, WP=2, RD=3, TURN=1 cycles
  localparam int EXP_AS = 1, EXP_WP = 2, EXP_RD = 3, EXP_TURN = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hA5A5;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  asram_ctrl #(
    .ADDR_W(18), .CLK_PS(20000), .T_WEHZ_PS(20000), .T_WP_PS(35000),
    .T_SD_PS(20000), .T_WC_PS(45000), .T_RD_PS(45000), .T_HZ_PS(15000)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // RAM model and bus monitors, all on the falling edge
  logic [15:0] ram [0:255];
  int rcnt = 0, cyc = 0, last_drive = -10, turn_gap = -1;
  int we_rises = 0, contention = 0, early_drive = 0, undriven_wr = 0, oe_in_write = 0;
  int lb_run = 0, ub_run = 0, stb_min = 1000, stb_max = 0, setup_run = 0, setup_last = -1;
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_lb = 1'b1, prev_ub = 1'b1;

  initial for (int i = 0; i < 256; i++) ram[i] = 16'h0000;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!mem_ce_n && !mem_we_n && !mem_lb_n) begin
        if (mem_dq_oe) ram[mem_addr[7:0]][7:0] = mem_dq_out[7:0]; else undriven_wr++;
      end
      if (!mem_ce_n && !mem_we_n && !mem_ub_n) begin
        if (mem_dq_oe) ram[mem_addr[7:0]][15:8] = mem_dq_out[15:8]; else undriven_wr++;
      end
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rcnt++; else rcnt = 0;
      mem_dq_in[7:0]  = (rcnt >= EXP_RD && !mem_lb_n) ? ram[mem_addr[7:0]][7:0]  : 8'hA5;
      mem_dq_in[15:8] = (rcnt >= EXP_RD && !mem_ub_n) ? ram[mem_addr[7:0]][15:8] : 8'hA5;
      if (mem_dq_oe && !mem_oe_n) contention++;
      if (!mem_we_n && !mem_oe_n) oe_in_write++;
      if (!mem_we_n && prev_we && mem_dq_oe) early_drive++;
      if (mem_we_n && !prev_we) we_rises++;
      if (mem_dq_oe) last_drive = cyc;
      if (!mem_oe_n && prev_oe) turn_gap = cyc - last_drive - 1;
      // strobe widths during writes
      if (!mem_we_n) begin
        if (!mem_lb_n) lb_run++;
        if (!mem_ub_n) ub_run++;
      end
      if (mem_lb_n && !prev_lb && lb_run > 0) begin
        if (lb_run < stb_min) stb_min = lb_run;
        if (lb_run > stb_max) stb_max = lb_run;
        lb_run = 0;
      end
      if (mem_ub_n && !prev_ub && ub_run > 0) begin
        if (ub_run < stb_min) stb_min = ub_run;
        if (ub_run > stb_max) stb_max = ub_run;
        ub_run = 0;
      end
      // address/bus setup from write enable fall
      if (!mem_we_n && prev_we) setup_run = 1;
      else if (setup_run > 0 && !mem_we_n && mem_lb_n && mem_ub_n) setup_run++;
      else if (setup_run > 0 && !(mem_lb_n && mem_ub_n)) begin setup_last = setup_run; setup_run = 0; end
      prev_we = mem_we_n; prev_oe = mem_oe_n; prev_lb = mem_lb_n; prev_ub = mem_ub_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present a command at a falling edge; returns ready seen one cycle after acceptance.
  task automatic send(input bit wr, input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] m, output bit ready_after);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ready_after = req_ready;
  endtask

  task automatic wait_rsp(output logic [15:0] data, output int lat, output bit single);
    lat = 0;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    data = rsp_rdata;
    @(negedge clk);
    single = !rsp_valid;
  endtask

  task automatic idle_wait();
    while (!(req_ready && mem_we_n && mem_oe_n)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n, "R1 strobes",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'h1f);
    check(!mem_dq_oe && !rsp_valid && req_ready, "R1 bus/valid/ready",
          {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
  endtask

  task automatic t_write_read();
    bit rdy; logic [15:0] d; int lat; bit single;
    send(1'b1, 18'h00010, 16'h1234, 2'b11, rdy);
    check(!rdy, "R2 ready low after write accept", rdy, 0);
    idle_wait();
    send(1'b0, 18'h00010, 16'h0, 2'b11, rdy);
    check(!rdy, "R2 ready low after read accept", rdy, 0);
    wait_rsp(d, lat, single);
    check(d == 16'h1234, "R6 read word", d, 16'h1234);
    check(lat == EXP_RD, "R7 read latency", lat, EXP_RD);
    check(single, "R7 one-cycle valid", single, 1);
    idle_wait();
  endtask

  task automatic t_lanes();
    bit rdy; logic [15:0] d; int lat; bit single;
    send(1'b1, 18'h00020, 16'hAAAA, 2'b11, rdy); idle_wait();
    send(1'b1, 18'h00020, 16'h1155, 2'b01, rdy); idle_wait();
    send(1'b1, 18'h00020, 16'h6622, 2'b10, rdy); idle_wait();
    send(1'b0, 18'h00020, 16'h0, 2'b11, rdy);
    wait_rsp(d, lat, single);
    check(d == 16'h6655, "R5 lane merge", d, 16'h6655);
    idle_wait();
    send(1'b0, 18'h00020, 16'h0, 2'b01, rdy);
    wait_rsp(d, lat, single);
    check(d == 16'h0055, "R6 low lane only, upper zero", d, 16'h0055);
    idle_wait();
    send(1'b0, 18'h00020, 16'h0, 2'b10, rdy);
    wait_rsp(d, lat, single);
    check(d == 16'h6600, "R6 high lane only, lower zero", d, 16'h6600);
    idle_wait();
  endtask

  task automatic t_mask_none();
    bit rdy; logic [15:0] d; int lat; bit single;
    send(1'b1, 18'h00020, 16'hFFFF, 2'b00, rdy); idle_wait();
    send(1'b0, 18'h00020, 16'h0, 2'b11, rdy);
    wait_rsp(d, lat, single);
    check(d == 16'h6655, "R5 mask 00 write ignored", d, 16'h6655);
    idle_wait();
  endtask

  task automatic t_burst();
    bit rdy; logic [15:0] d; int lat; bit single; int rises0;
    rises0 = we_rises;
    send(1'b1, 18'h00030, 16'hC001, 2'b11, rdy);
    send(1'b1, 18'h00031, 16'hC002, 2'b11, rdy);
    send(1'b1, 18'h00032, 16'hC003, 2'b11, rdy);
    idle_wait();
    check(we_rises - rises0 == 1, "R8 single WE rise in chain", we_rises - rises0, 1);
    for (int i = 0; i < 3; i++) begin
      send(1'b0, 18'h00030 + 18'(i), 16'h0, 2'b11, rdy);
      wait_rsp(d, lat, single);
      check(d == 16'hC001 + 16'(i), "R8 chained word", d, 16'hC001 + i);
      idle_wait();
    end
  endtask

  task automatic t_write_then_read();
    bit rdy; logic [15:0] d; int lat; bit single;
    send(1'b1, 18'h00040, 16'hBEEF, 2'b11, rdy);
    send(1'b0, 18'h00040, 16'h0, 2'b11, rdy);
    wait_rsp(d, lat, single);
    check(d == 16'hBEEF, "R9 read after chained write", d, 16'hBEEF);
    check(turn_gap == EXP_TURN, "R9 turnaround gap", turn_gap, EXP_TURN);
    idle_wait();
  endtask

  task automatic t_monitors();
    check(contention == 0, "R9 bus contention", contention, 0);
    check(early_drive == 0, "R4 drive at WE fall", early_drive, 0);
    check(undriven_wr == 0, "R4 write without data", undriven_wr, 0);
    check(oe_in_write == 0, "R3 OE low while writing", oe_in_write, 0);
    check(stb_min == EXP_WP && stb_max == EXP_WP, "R3 strobe width", stb_min, EXP_WP);
    check(setup_last == EXP_AS, "R10 setup cycles", setup_last, EXP_AS);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_lanes();
    t_mask_none();
    t_burst();
    t_write_then_read();
    t_monitors();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule